// File: doc/BRIEF.md
# Linear CCD Readout Timer

This block drives a linear CCD image sensor from a fast system clock. It runs a free-running master clock for the sensor. On request it issues the charge-transfer pulse pair: the integration-clear gate drops, the shift gate pulses inside it, and then the clear gate is released. It also gives an external converter a one-cycle sample strobe and the index of the pixel that is being shifted out.

The sensor shifts out one pixel every two master clock periods, starting at the release edge of the clear gate. The block therefore releases that gate only on a rising edge of the master clock and starts its pixel phase at that same edge, so every strobe falls on a pixel boundary.

The falling edge of the shift gate starts a new integration period, and a one-cycle marker reports it. A later transfer is held back until the current frame has been read out and the requested minimum integration time has passed. A build-time switch inverts all three sensor drive lines, so the block can drive the sensor through an inverting buffer.

All durations are counts of system-clock cycles. At a 50 MHz system clock the defaults give a 200 ns lead from the clear gate to the shift gate, a 1.2 us shift pulse, a release gap of at least 1.2 us, and a 1.28 us master clock period.

Top module: `ccdReadoutTimer`

## Requirements
- R1: During reset and whenever no transfer is in progress, the shift gate is low and the clear gate is high (both before the optional inversion).
- R2: The master clock runs without stopping, with a period of 2*HALF_CYC system cycles and a 50% duty cycle. It is high for the first HALF_CYC cycles after reset is released.
- R3: A transfer runs in a fixed order. The clear gate falls. Exactly ICG_SH_CYC cycles later the shift gate rises and stays high for exactly SH_ON_CYC cycles. The clear gate rises at least SH_ICG_CYC cycles after the shift gate falls, and fewer than SH_ICG_CYC + 2*HALF_CYC cycles after it.
- R4: The clear gate rises in the same cycle as a rising edge of the master clock.
- R5: Readout starts in the cycle in which the clear gate rises. A one-cycle sample strobe fires in that cycle and again every 4*HALF_CYC cycles after it, for exactly LEAD_PIX+IMAGE_PIX+TRAIL_PIX strobes. The pixel index is 0 at the first strobe, counts up by one at each later strobe, and holds its value between strobes.
- R6: The image-valid output is high during readout exactly while the pixel index lies between LEAD_PIX and LEAD_PIX+IMAGE_PIX-1, both ends included.
- R7: The frame-done output pulses for one cycle, 4*HALF_CYC cycles after the last strobe. During that pulse the clear gate is high and the shift gate is low, and the block is idle.
- R8: The integration-start output is high for exactly one cycle: the first cycle in which the shift gate is low again after its pulse.
- R9: A one-cycle start request made while the block is idle and the integration time has been met makes the clear gate fall in the next cycle. A request made during a transfer or readout is kept and served after frame-done.
- R10: Let the integration-start pulse be seen in cycle t. The clear gate does not fall before cycle t+minInt+1. Once a request is pending and the frame has ended, it falls in exactly the later of that cycle and the cycle after frame-done.
- R11: With INVERT set, the master clock, shift gate and clear gate pins are the bitwise complements of those of a non-inverted instance, and all other outputs are the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startReq | input | 1 | Request for a transfer and frame readout |
| minInt | input | INT_W | Minimum integration time in system cycles |
| fmOut | output | 1 | Sensor master clock pin |
| shOut | output | 1 | Sensor shift gate pin |
| icgOut | output | 1 | Sensor integration-clear gate pin |
| sampleStrobe | output | 1 | One-cycle strobe at the start of each pixel |
| pixelIndex | output | PIX_W | Index of the pixel being shifted out |
| imageValid | output | 1 | High while the current pixel is an image pixel |
| frameDone | output | 1 | One-cycle pulse at the end of a frame |
| intStart | output | 1 | One-cycle marker for the start of integration |

## Verification
The bench builds the block with a master clock half period of 2 cycles, transfer delays of 3, 4 and 5 cycles, and a frame of 2+5+1 pixels. A full frame therefore lasts under a hundred cycles. This lets the bench place start requests at every master-clock phase and lets it check each strobe, index and valid flag cycle by cycle against its own arithmetic.

With these short frames the bench can also set minimum integration times both below and above the readout length. That puts both branches of the start-time rule within reach: waiting for the frame to end, and waiting out the rest of the integration time. A second instance built with inversion runs beside the first, and the bench compares the two pin by pin.

// File: rtl/ccd_timing_pkg.sv
package ccd_timing_pkg;

  typedef enum logic [1:0] {
    DLY_ICG_SH,
    DLY_SH_ON,
    DLY_SH_ICG
  } dlySel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ICGLOW,
    ST_SHON,
    ST_GAP,
    ST_READ
  } ctrlState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic    loadDly;
    dlySel_e dlySel;
    logic    restartInt;
    logic    startPix;
    logic    runPix;
  } ctrlStrobe_t;

endpackage

// File: rtl/ccd_timing_datapath.sv
module ccd_timing_datapath
  import ccd_timing_pkg::*;
#(
  parameter int HALF_CYC   = 32,
  parameter int ICG_SH_CYC = 10,
  parameter int SH_ON_CYC  = 60,
  parameter int SH_ICG_CYC = 60,
  parameter int LEAD_PIX   = 32,
  parameter int IMAGE_PIX  = 1500,
  parameter int NUM_PIX    = 1546,
  parameter int INT_W      = 24,
  localparam int PIX_W     = $clog2(NUM_PIX)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctrl,
  input  logic [INT_W-1:0]  minInt,
  output logic              fmLevel,
  output logic              fmWrap,
  output logic              dlyDone,
  output logic              intMet,
  output logic              pixLast,
  output logic              pixOdd,
  output logic              sampleStrobe,
  output logic [PIX_W-1:0]  pixIdx,
  output logic              imageValid
);

  localparam int PERIOD   = 2 * HALF_CYC;
  localparam int PH_W     = $clog2(PERIOD);
  localparam int DLY_A    = (ICG_SH_CYC > SH_ON_CYC) ? ICG_SH_CYC : SH_ON_CYC;
  localparam int DLY_MAX  = (DLY_A > SH_ICG_CYC) ? DLY_A : SH_ICG_CYC;
  localparam int DLY_W    = $clog2(DLY_MAX + 1);
  localparam int LAST_PIX = NUM_PIX - 1;
  localparam int IMG_END  = LEAD_PIX + IMAGE_PIX;

  logic [PH_W-1:0]  phase;
  logic [DLY_W-1:0] dly;
  logic [DLY_W-1:0] dlyLoad;
  logic [INT_W-1:0] intCnt;

  // master clock phase, free running
  assign fmWrap  = (phase == PH_W'(PERIOD - 1));
  assign fmLevel = (phase < PH_W'(HALF_CYC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       phase <= '0;
    else if (fmWrap) phase <= '0;
    else             phase <= phase + 1'b1;
  end

  // transfer pulse delay counter
  always_comb begin
    unique case (ctrl.dlySel)
      DLY_ICG_SH: dlyLoad = DLY_W'(ICG_SH_CYC - 1);
      DLY_SH_ON:  dlyLoad = DLY_W'(SH_ON_CYC - 1);
      default:    dlyLoad = DLY_W'(SH_ICG_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dly <= '0;
    else if (ctrl.loadDly) dly <= dlyLoad;
    else if (dly != '0)    dly <= dly - 1'b1;
  end

  assign dlyDone = (dly == '0);

  // integration time counter, saturating; starts saturated
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                intCnt <= '1;
    else if (ctrl.restartInt) intCnt <= '0;
    else if (intCnt != '1)    intCnt <= intCnt + 1'b1;
  end

  assign intMet = (intCnt >= minInt);

  // pixel position: two master clock periods per pixel
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixIdx <= '0;
      pixOdd <= 1'b0;
    end else if (ctrl.startPix) begin
      pixIdx <= '0;
      pixOdd <= 1'b0;
    end else if (ctrl.runPix && fmWrap) begin
      pixOdd <= ~pixOdd;
      if (pixOdd && !pixLast) pixIdx <= pixIdx + 1'b1;
    end
  end

  assign pixLast      = (pixIdx == PIX_W'(LAST_PIX));
  assign sampleStrobe = ctrl.runPix && (phase == '0) && !pixOdd;
  assign imageValid   = ctrl.runPix && (pixIdx >= PIX_W'(LEAD_PIX))
                        && (pixIdx < PIX_W'(IMG_END));

  // R5
  pix_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.runPix && $past(ctrl.runPix) && pixIdx != $past(pixIdx))
      |-> (pixIdx == $past(pixIdx) + 1'b1) && $past(fmWrap) && $past(pixOdd));

  // R6
  pix_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixIdx <= PIX_W'(LAST_PIX));

endmodule

// File: rtl/ccd_timing_ctrl.sv
module ccd_timing_ctrl
  import ccd_timing_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        fmWrap,
  input  logic        fmLevel,
  input  logic        dlyDone,
  input  logic        intMet,
  input  logic        pixLast,
  input  logic        pixOdd,
  output ctrlStrobe_t ctrl,
  output logic        shLevel,
  output logic        icgLevel,
  output logic        intStart,
  output logic        frameDone
);

  ctrlState_e state, nextState;
  logic pending;
  logic go;
  logic doneNext;

  assign go = (state == ST_IDLE) && (pending || startReq) && intMet;

  always_comb begin
    nextState   = state;
    ctrl        = '0;
    ctrl.dlySel = DLY_ICG_SH;
    ctrl.runPix = (state == ST_READ);
    doneNext    = 1'b0;
    unique case (state)
      ST_IDLE: if (go) begin
        nextState    = ST_ICGLOW;
        ctrl.loadDly = 1'b1;
        ctrl.dlySel  = DLY_ICG_SH;
      end
      ST_ICGLOW: if (dlyDone) begin
        nextState    = ST_SHON;
        ctrl.loadDly = 1'b1;
        ctrl.dlySel  = DLY_SH_ON;
      end
      ST_SHON: if (dlyDone) begin
        nextState       = ST_GAP;
        ctrl.loadDly    = 1'b1;
        ctrl.dlySel     = DLY_SH_ICG;
        ctrl.restartInt = 1'b1;
      end
      ST_GAP: if (dlyDone && fmWrap) begin
        nextState     = ST_READ;
        ctrl.startPix = 1'b1;
      end
      ST_READ: if (fmWrap && pixOdd && pixLast) begin
        nextState = ST_IDLE;
        doneNext  = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pending   <= 1'b0;
      shLevel   <= 1'b0;
      icgLevel  <= 1'b1;
      intStart  <= 1'b0;
      frameDone <= 1'b0;
    end else begin
      state     <= nextState;
      pending   <= (pending || startReq) && !go;
      shLevel   <= (nextState == ST_SHON);
      icgLevel  <= !(nextState inside {ST_ICGLOW, ST_SHON, ST_GAP});
      intStart  <= (state == ST_SHON) && (nextState == ST_GAP);
      frameDone <= doneNext;
    end
  end

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> (!shLevel && icgLevel));

  // R3
  sh_inside_icg_chk: assert property (@(posedge clk) disable iff (!rstN)
    shLevel |-> !icgLevel);

  // R4
  icg_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(icgLevel) |-> (fmLevel && $past(fmWrap)));

  // R8
  int_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    intStart |-> $fell(shLevel));

  // R10
  int_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(icgLevel) |-> $past(intMet));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> (icgLevel && !shLevel && state == ST_IDLE));

endmodule

// File: rtl/ccdReadoutTimer.sv
module ccdReadoutTimer
  import ccd_timing_pkg::*;
#(
  parameter int HALF_CYC   = 32,
  parameter int ICG_SH_CYC = 10,
  parameter int SH_ON_CYC  = 60,
  parameter int SH_ICG_CYC = 60,
  parameter int LEAD_PIX   = 32,
  parameter int IMAGE_PIX  = 1500,
  parameter int TRAIL_PIX  = 14,
  parameter int INT_W      = 24,
  parameter bit INVERT     = 1'b0,
  localparam int NUM_PIX   = LEAD_PIX + IMAGE_PIX + TRAIL_PIX,
  localparam int PIX_W     = $clog2(NUM_PIX)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [INT_W-1:0] minInt,
  output logic             fmOut,
  output logic             shOut,
  output logic             icgOut,
  output logic             sampleStrobe,
  output logic [PIX_W-1:0] pixelIndex,
  output logic             imageValid,
  output logic             frameDone,
  output logic             intStart
);

  ctrlStrobe_t ctrl;
  logic fmLevel, fmWrap, dlyDone, intMet, pixLast, pixOdd;
  logic shLevel, icgLevel;

  ccd_timing_datapath #(
    .HALF_CYC  (HALF_CYC),
    .ICG_SH_CYC(ICG_SH_CYC),
    .SH_ON_CYC (SH_ON_CYC),
    .SH_ICG_CYC(SH_ICG_CYC),
    .LEAD_PIX  (LEAD_PIX),
    .IMAGE_PIX (IMAGE_PIX),
    .NUM_PIX   (NUM_PIX),
    .INT_W     (INT_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .minInt      (minInt),
    .fmLevel     (fmLevel),
    .fmWrap      (fmWrap),
    .dlyDone     (dlyDone),
    .intMet      (intMet),
    .pixLast     (pixLast),
    .pixOdd      (pixOdd),
    .sampleStrobe(sampleStrobe),
    .pixIdx      (pixelIndex),
    .imageValid  (imageValid)
  );

  ccd_timing_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .fmWrap   (fmWrap),
    .fmLevel  (fmLevel),
    .dlyDone  (dlyDone),
    .intMet   (intMet),
    .pixLast  (pixLast),
    .pixOdd   (pixOdd),
    .ctrl     (ctrl),
    .shLevel  (shLevel),
    .icgLevel (icgLevel),
    .intStart (intStart),
    .frameDone(frameDone)
  );

  generate
    if (INVERT) begin : gInvPins
      assign fmOut  = ~fmLevel;
      assign shOut  = ~shLevel;
      assign icgOut = ~icgLevel;
    end else begin : gDirectPins
      assign fmOut  = fmLevel;
      assign shOut  = shLevel;
      assign icgOut = icgLevel;
    end
  endgenerate

endmodule

// File: tb/sim_ccdReadoutTimer.sv
module sim_ccdReadoutTimer;

  localparam int H     = 2;
  localparam int P     = 2 * H;
  localparam int PIXP  = 2 * P;
  localparam int ICS   = 3;
  localparam int SHO   = 4;
  localparam int SIC   = 5;
  localparam int LEAD  = 2;
  localparam int IMG   = 5;
  localparam int TRAIL = 1;
  localparam int N     = LEAD + IMG + TRAIL;
  localparam int IW    = 12;
  localparam int PW    = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [IW-1:0] minInt = '0;

  logic fm0, sh0, icg0, stb0, val0, done0, is0;
  logic fm1, sh1, icg1, stb1, val1, done1, is1;
  logic [PW-1:0] idx0, idx1;

  always #5 clk = ~clk;

  ccdReadoutTimer #(.HALF_CYC(H), .ICG_SH_CYC(ICS), .SH_ON_CYC(SHO), .SH_ICG_CYC(SIC),
    .LEAD_PIX(LEAD), .IMAGE_PIX(IMG), .TRAIL_PIX(TRAIL), .INT_W(IW), .INVERT(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .minInt(minInt),
    .fmOut(fm0), .shOut(sh0), .icgOut(icg0), .sampleStrobe(stb0), .pixelIndex(idx0),
    .imageValid(val0), .frameDone(done0), .intStart(is0));

  ccdReadoutTimer #(.HALF_CYC(H), .ICG_SH_CYC(ICS), .SH_ON_CYC(SHO), .SH_ICG_CYC(SIC),
    .LEAD_PIX(LEAD), .IMAGE_PIX(IMG), .TRAIL_PIX(TRAIL), .INT_W(IW), .INVERT(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .minInt(minInt),
    .fmOut(fm1), .shOut(sh1), .icgOut(icg1), .sampleStrobe(stb1), .pixelIndex(idx1),
    .imageValid(val1), .frameDone(done1), .intStart(is1));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wd = 0;
  int lastReq = -1000;
  int lastDone = -1000;
  int lastInt = -1;
  int tFall = 0, tRise = 0, tShFall = 0, tRel = 0;
  int nStrobe = 0;
  int frames = 0;
  bit busy = 1'b0;
  bit reading = 1'b0;
  bit prevIcg = 1'b1, prevSh = 1'b0, prevFm = 1'b1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      check(1'b0, "watchdog", wd, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // cycle-by-cycle monitor, sampled away from the active edge
  always @(negedge clk) begin
    int k, expF;
    bit expStb, expVal, expDone;
    if (!rstN) begin
      // R1 reset state
      check(!sh0 && icg0 && fm0 && !stb0 && !done0 && !is0, "R1 reset levels",
            {sh0, icg0, fm0, stb0, done0, is0}, 6'b011000);
    end else begin
      // R2
      check(fm0 == ((cyc % P) < H), "R2 master clock", fm0, (cyc % P) < H);
      // R11
      check(fm1 == !fm0 && sh1 == !sh0 && icg1 == !icg0 && stb1 == stb0 && idx1 == idx0
            && val1 == val0 && done1 == done0 && is1 == is0, "R11 inverted instance",
            {fm1, sh1, icg1}, {!fm0, !sh0, !icg0});
      if (prevIcg && !icg0) begin
        expF = lastReq + 1;
        if (lastDone + 1 > expF) expF = lastDone + 1;
        if (lastInt >= 0 && lastInt + int'(minInt) + 1 > expF) expF = lastInt + int'(minInt) + 1;
        // R9 / R10 start time
        check(cyc == expF, "R10 clear gate fall cycle", cyc, expF);
        tFall = cyc;
        busy = 1'b1;
      end
      if (!prevSh && sh0) begin
        check(cyc - tFall == ICS, "R3 lead to shift gate", cyc - tFall, ICS);
        tRise = cyc;
      end
      if (prevSh && !sh0) begin
        check(cyc - tRise == SHO, "R3 shift gate width", cyc - tRise, SHO);
        tShFall = cyc;
      end
      check(is0 == (prevSh && !sh0), "R8 integration marker", is0, prevSh && !sh0);
      if (is0) lastInt = cyc;
      if (!prevIcg && icg0 && busy) begin
        check(cyc - tShFall >= SIC && cyc - tShFall < SIC + P, "R3 release gap",
              cyc - tShFall, SIC);
        check(fm0 && !prevFm && (cyc % P) == 0, "R4 release on clock rise", fm0, 1);
        reading = 1'b1;
        tRel = cyc;
        nStrobe = 0;
      end
      if (!busy) check(!sh0 && icg0, "R1 idle levels", {sh0, icg0}, 2'b01);
      k = reading ? cyc - tRel : 0;
      expStb = reading && (k % PIXP) == 0 && (k / PIXP) < N;
      check(stb0 == expStb, "R5 sample strobe", stb0, expStb);
      if (stb0) nStrobe++;
      if (reading && k < PIXP * N)
        check(int'(idx0) == k / PIXP, "R5 pixel index", idx0, k / PIXP);
      expVal = reading && k < PIXP * N && (k / PIXP) >= LEAD && (k / PIXP) < LEAD + IMG;
      check(val0 == expVal, "R6 image valid", val0, expVal);
      expDone = reading && k == PIXP * N;
      check(done0 == expDone, "R7 frame done", done0, expDone);
      if (done0) begin
        check(nStrobe == N, "R5 strobe count", nStrobe, N);
        check(icg0 && !sh0, "R7 levels at frame end", {sh0, icg0}, 2'b01);
        reading = 1'b0;
        busy = 1'b0;
        lastDone = cyc;
        frames++;
      end
      prevIcg = icg0;
      prevSh = sh0;
      prevFm = fm0;
    end
  end

  task automatic req();
    startReq = 1'b1;
    lastReq = cyc;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitDone();
    @(negedge clk);
    while (!done0) @(negedge clk);
  endtask

  task automatic waitStrobe();
    @(negedge clk);
    while (!stb0) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R9 first request from idle, no integration limit
    repeat (3) @(negedge clk);
    req();
    waitDone();
    // R4 sweep of request phase against the master clock
    for (int d = 0; d < 8; d++) begin
      repeat (d + 1) @(negedge clk);
      req();
      waitDone();
    end
    // R10 integration limit longer than the frame
    minInt = 12'd150;
    req();
    waitDone();
    // R9 request kept during readout, limit shorter than the frame
    minInt = 12'd20;
    req();
    waitStrobe();
    req();
    waitDone();
    waitDone();
    // R10 request kept during readout, limit longer than the frame
    minInt = 12'd300;
    req();
    waitStrobe();
    req();
    waitDone();
    waitDone();
    // R9 request in the frame-done cycle itself
    minInt = 12'd0;
    req();
    waitDone();
    repeat (20) @(negedge clk);
    check(frames == 15, "R9 frames served", frames, 15);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule